// File: doc/BRIEF.md
# Partitioned Sub-Word Adder/Subtractor

This block adds or subtracts two 64-bit packed operands in a single pass, with the 64-bit word split at run time into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The datapath is a row of eight byte slices. Each slice uses carry-select: it forms the sum for an incoming carry of 0 and for an incoming carry of 1, and the real carry then picks one of the two. The lane-width mode decides which slices start a new lane. At a lane start the carry from the slice below is cut and the lane's initial carry is used in its place.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream, one cycle after the operands are accepted. Back-pressure works as follows. When the output holds a result that the consumer has not taken (`res_valid` high with `res_ready` low), that result and its carries stay frozen and `opd_ready` drops. `opd_ready` is high whenever the output register is empty, or is being emptied in the same cycle. This allows one transfer per clock when the consumer is always ready. The mode and the add/subtract select go with each operand beat.

Top module: `subword_addsub`

## Requirements
- R1: While reset is asserted and right after it, `res_valid` is 0 and `opd_ready` is 1.
- R2: With `lane_mode` = 2'b00 each byte lane i (bits 8i+7..8i) holds (A+B) mod 2^8 of that byte pair, and no carry crosses a byte boundary.
- R3: With `lane_mode` = 2'b01 each 16-bit lane holds its own sum mod 2^16, and no carry crosses a 16-bit boundary.
- R4: With `lane_mode` = 2'b10 each 32-bit lane holds its own sum mod 2^32, and no carry crosses a 32-bit boundary.
- R5: With `lane_mode` = 2'b11 the whole word holds (A+B) mod 2^64, so a carry ripples through all eight slices.
- R6: With `sub_sel` = 1 every lane holds (A-B) mod 2^w for its width w. This is computed as A + ~B + 1 per lane.
- R7: `res_carry[i]` gives the raw carry out of the lane whose top byte is byte i (for a subtraction, 1 means no borrow). Bits for bytes that are not the top of a lane are 0.
- R8: An operand beat accepted at a clock edge appears on `res_sum`/`res_carry` with `res_valid` = 1 right after that edge. `res_valid` falls after a transfer that has no new beat behind it.
- R9: While `res_valid` = 1 and `res_ready` = 0, the output data and carries stay unchanged and `opd_ready` = 0.
- R10: `opd_ready` equals `!res_valid || res_ready`, so a result can be drained and a new beat taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opd_valid | input | 1 | Operand beat valid |
| opd_ready | output | 1 | Operand beat can be taken |
| opd_a | input | 64 | Packed operand A |
| opd_b | input | 64 | Packed operand B |
| lane_mode | input | 2 | Lane width: 00 byte, 01 16-bit, 10 32-bit, 11 64-bit |
| sub_sel | input | 1 | 1 = subtract B from A in every lane |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer takes the result |
| res_sum | output | 64 | Packed lane results |
| res_carry | output | 8 | Lane carry-out at each lane's top byte, else 0 |

## Verification
The hardest cases to reach are a carry that must travel across every slice boundary and a carry that must be stopped at a boundary. Both come from all-ones plus one, and from zero minus one, in each mode. With these values every slice's carry-select mux is chosen by the slice below, or cut by a lane start. The second hard case is an output stall while a new beat waits at the input. The consumer's ready signal is held low for stretches and then driven randomly while operand beats are offered back to back. The reference model tracks the pending result and the expected ready value on every clock.

// File: rtl/subword_pkg.sv
package subword_pkg;
  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/cs_byte_slice.sv
// One carry-select slice: both carry hypotheses computed in parallel,
// the real carry-in picks one at the end.
module cs_byte_slice #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout
);
  logic [SLICE_W:0] sum_c0;
  logic [SLICE_W:0] sum_c1;

  always_comb begin
    sum_c0 = {1'b0, a} + {1'b0, b};
    sum_c1 = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, 1'b1};
  end

  always_comb begin
    if (cin) begin
      sum  = sum_c1[SLICE_W-1:0];
      cout = sum_c1[SLICE_W];
    end else begin
      sum  = sum_c0[SLICE_W-1:0];
      cout = sum_c0[SLICE_W];
    end
  end
endmodule

// File: rtl/lane_map.sv
// Decodes the lane-width mode into per-slice lane-start and lane-top masks.
module lane_map #(
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input  logic [MODE_W-1:0]     mode,
  output logic [NUM_SLICES-1:0] start_mask,
  output logic [NUM_SLICES-1:0] top_mask
);
  localparam int SIDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  logic [SIDX_W-1:0] span_m1;

  always_comb begin
    span_m1 = SIDX_W'((32'd1 << mode) - 32'd1);
  end

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam logic [SIDX_W-1:0] IDX = SIDX_W'(i);
    assign start_mask[i] = ((IDX & span_m1) == '0);
    assign top_mask[i]   = ((IDX & span_m1) == span_m1);
  end
endmodule

// File: rtl/partitioned_core.sv
// Combinational chain of carry-select slices with mode-controlled cuts.
module partitioned_core #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] a,
  input  logic [SLICE_W*NUM_SLICES-1:0] b,
  input  logic [MODE_W-1:0]             mode,
  input  logic                          sub,
  output logic [SLICE_W*NUM_SLICES-1:0] sum,
  output logic [NUM_SLICES-1:0]         lane_carry
);
  localparam int DATA_W = SLICE_W * NUM_SLICES;

  logic [DATA_W-1:0]     b_eff;
  logic [NUM_SLICES-1:0] start_mask;
  logic [NUM_SLICES-1:0] top_mask;
  logic [NUM_SLICES-1:0] cin;
  logic [NUM_SLICES-1:0] cout;

  assign b_eff = b ^ {DATA_W{sub}};

  lane_map #(
    .NUM_SLICES(NUM_SLICES),
    .MODE_W    (MODE_W)
  ) map_i (
    .mode      (mode),
    .start_mask(start_mask),
    .top_mask  (top_mask)
  );

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign cin[i] = sub;
    end else begin : g_link
      assign cin[i] = start_mask[i] ? sub : cout[i-1];
    end

    cs_byte_slice #(
      .SLICE_W(SLICE_W)
    ) slice_i (
      .a   (a[i*SLICE_W +: SLICE_W]),
      .b   (b_eff[i*SLICE_W +: SLICE_W]),
      .cin (cin[i]),
      .sum (sum[i*SLICE_W +: SLICE_W]),
      .cout(cout[i])
    );
  end

  assign lane_carry = cout & top_mask;
endmodule

// File: rtl/subword_addsub.sv
module subword_addsub #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          opd_valid,
  output logic                          opd_ready,
  input  logic [SLICE_W*NUM_SLICES-1:0] opd_a,
  input  logic [SLICE_W*NUM_SLICES-1:0] opd_b,
  input  logic [MODE_W-1:0]             lane_mode,
  input  logic                          sub_sel,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [SLICE_W*NUM_SLICES-1:0] res_sum,
  output logic [NUM_SLICES-1:0]         res_carry
);
  localparam int DATA_W = SLICE_W * NUM_SLICES;

  logic [DATA_W-1:0]     core_sum;
  logic [NUM_SLICES-1:0] core_carry;
  logic                  take;

  partitioned_core #(
    .SLICE_W   (SLICE_W),
    .NUM_SLICES(NUM_SLICES),
    .MODE_W    (MODE_W)
  ) core_i (
    .a         (opd_a),
    .b         (opd_b),
    .mode      (lane_mode),
    .sub       (sub_sel),
    .sum       (core_sum),
    .lane_carry(core_carry)
  );

  assign opd_ready = !res_valid || res_ready;
  assign take      = opd_valid && opd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_carry <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_sum   <= core_sum;
      res_carry <= core_carry;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/subword_addsub_chk.sv
module subword_addsub_chk
  import subword_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          opd_valid,
  input logic                          opd_ready,
  input logic [MODE_W-1:0]             lane_mode,
  input logic                          res_valid,
  input logic                          res_ready,
  input logic [SLICE_W*NUM_SLICES-1:0] res_sum,
  input logic [NUM_SLICES-1:0]         res_carry
);
  p_accept_gives_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready) |=> res_valid);

  p_idle_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !opd_valid) |=> !res_valid);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_sum) && $stable(res_carry)));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !opd_ready);

  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> opd_ready);

  p_wide_carry_top_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready && lane_mode == MODE_W'(LANE_64))
    |=> (res_carry[NUM_SLICES-2:0] == '0));

  p_half_carry_tops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && opd_ready && lane_mode == MODE_W'(LANE_32))
    |=> ($countones(res_carry) <= 2));
endmodule

bind subword_addsub subword_addsub_chk #(
  .SLICE_W   (SLICE_W),
  .NUM_SLICES(NUM_SLICES),
  .MODE_W    (MODE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .opd_valid(opd_valid),
  .opd_ready(opd_ready),
  .lane_mode(lane_mode),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_sum  (res_sum),
  .res_carry(res_carry)
);

// File: tb/subword_addsub_tb_top.sv
`timescale 1ns/1ps
module subword_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opd_valid = 1'b0;
  logic        opd_ready;
  logic [63:0] opd_a = '0;
  logic [63:0] opd_b = '0;
  logic [1:0]  lane_mode = 2'b00;
  logic        sub_sel = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_sum;
  logic [7:0]  res_carry;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit run   = 1'b0;
  bit done  = 1'b0;
  int rdy_policy = 0;

  logic [63:0] q_sum[$];
  logic [7:0]  q_car[$];
  string       q_req[$];

  always #4 clk = ~clk;

  subword_addsub dut_i (
    .clk(clk), .rst_n(rst_n),
    .opd_valid(opd_valid), .opd_ready(opd_ready),
    .opd_a(opd_a), .opd_b(opd_b), .lane_mode(lane_mode), .sub_sel(sub_sel),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_sum(res_sum), .res_carry(res_carry)
  );

  // Behavioural lane arithmetic from the requirements.
  task automatic ref_calc(input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] mode, input logic sub,
                          output logic [63:0] s, output logic [7:0] c);
    int w;
    logic [64:0] mask, av, bv, t;
    w = 8 << mode;
    mask = (65'd1 << w) - 65'd1;
    s = '0;
    c = '0;
    for (int k = 0; k < 64 / w; k++) begin
      av = ({1'b0, a} >> (k * w)) & mask;
      bv = ({1'b0, b} >> (k * w)) & mask;
      if (sub) bv = (~bv) & mask;
      t = av + bv + {64'd0, sub};
      s = s | 64'((t & mask) << (k * w));
      c[((k + 1) * w / 8) - 1] = t[w];
    end
  endtask

  function automatic string req_of(input logic [1:0] mode, input logic sub);
    if (sub) return "R6";
    case (mode)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // Reference model: one pending result at most, updated per clock.
  always @(posedge clk) begin
    if (!rst_n) begin
      q_sum.delete(); q_car.delete(); q_req.delete();
    end else begin
      if (res_valid && res_ready && q_sum.size() != 0) begin
        void'(q_sum.pop_front()); void'(q_car.pop_front()); void'(q_req.pop_front());
      end
      if (opd_valid && opd_ready) begin
        logic [63:0] s;
        logic [7:0]  c;
        ref_calc(opd_a, opd_b, lane_mode, sub_sel, s, c);
        q_sum.push_back(s); q_car.push_back(c); q_req.push_back(req_of(lane_mode, sub_sel));
      end
    end
  end

  // Compare every clock, away from the active edge.
  always begin
    @(negedge clk);
    #2;
    if (rst_n && run && !done) begin
      logic exp_v, exp_r;
      exp_v = (q_sum.size() != 0);
      exp_r = !exp_v || res_ready;
      tests++;
      if (res_valid !== exp_v) begin
        fails++;
        $display("FAIL R8 res_valid actual=%0b expected=%0b", res_valid, exp_v);
      end
      tests++;
      if (opd_ready !== exp_r) begin
        fails++;
        $display("FAIL %s opd_ready actual=%0b expected=%0b",
                 (exp_v && !res_ready) ? "R9" : "R10", opd_ready, exp_r);
      end
      if (exp_v) begin
        tests++;
        if (res_sum !== q_sum[0]) begin
          fails++;
          $display("FAIL %s res_sum actual=%h expected=%h", q_req[0], res_sum, q_sum[0]);
        end
        tests++;
        if (res_carry !== q_car[0]) begin
          fails++;
          $display("FAIL R7 res_carry actual=%b expected=%b", res_carry, q_car[0]);
        end
      end
    end
  end

  // Consumer ready policy.
  always @(negedge clk) begin
    case (rdy_policy)
      0:       res_ready <= 1'b1;
      1:       res_ready <= 1'b0;
      default: res_ready <= ($urandom % 3) != 0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R8 watchdog actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] mode, input logic sub);
    @(negedge clk);
    opd_valid = 1'b1;
    opd_a = a; opd_b = b; lane_mode = mode; sub_sel = sub;
    do @(posedge clk); while (!opd_ready);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    opd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    tests++;
    if (res_valid !== 1'b0 || opd_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset actual valid=%0b ready=%0b expected valid=0 ready=1",
               res_valid, opd_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    #2;
    tests++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset res_valid actual=%0b expected=0", res_valid);
    end

    // Carry cut / full ripple in every mode (R2..R7), back to back (R10).
    for (int m = 0; m < 4; m++) begin
      send('1, 64'd1, 2'(m), 1'b0);
      send(64'd0, 64'd1, 2'(m), 1'b1);
      send(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'(m), 1'b0);
      send(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'(m), 1'b0);
      send(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'(m), 1'b1);
    end
    idle(2);

    // Stall with a waiting beat (R9).
    rdy_policy = 1;
    send(64'hFFFF_0000_FFFF_0000, 64'h0001_0000_0001_0000, 2'b01, 1'b0);
    @(negedge clk);
    opd_a = 64'h0102_0304_0506_0708; opd_b = 64'h0807_0605_0403_0201;
    lane_mode = 2'b00; sub_sel = 1'b1;
    repeat (5) @(negedge clk);
    rdy_policy = 0;
    do @(posedge clk); while (!opd_ready);
    idle(2);

    // Random traffic with random back-pressure.
    rdy_policy = 2;
    for (int n = 0; n < 300; n++) begin
      send({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom % 4), 1'($urandom % 2));
      if ((n % 17) == 0) idle(1);
    end
    idle(1);
    rdy_policy = 0;
    for (int k = 0; k < 20 && q_sum.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule